// File: doc/BRIEF.md
# Command-Register MDIO Management Master

This block runs clause 22 management transactions toward Ethernet PHYs from a single 32-bit control word. Software writes one word that holds the target PHY, the PHY register, the direction, the outgoing data and two control bits (enable and busy). The block then clocks a complete frame out on MDC/MDIO. MDC is produced from the system clock by a divider.

When the frame ends, the block clears the busy bit by itself. After a read, it also puts the 16 bits returned by the PHY into the low half of the same word. Software therefore polls the word until busy reads zero, then takes the data from the low half. While a transaction is in flight, the word is locked against writes.

Top module: `mdio_cmd_master`

## Requirements
- R1: After synchronous reset the control word reads 0, MDC is low and MDIO is not driven (mdio_oe = 0).
- R2: Control word layout: bits [15:0] data, [20:16] PHY register number, [25:21] PHY address, bit 27 direction (1 = read, 0 = write), bit 30 enable, bit 31 busy. A write with bits 31 and 30 both set starts a frame and reads back with busy set. Bits [30:16] keep their written values through the whole transaction.
- R3: A write frame is, MSB first on MDIO, 32 ones, then 01, then opcode 01, PHY address, register number, turnaround 10, and the 16 data bits.
- R4: A read frame carries opcode 10. The master releases MDIO (mdio_oe = 0) from the first turnaround bit through the last data bit.
- R5: During a read, the master samples the 16 data bits on MDC rising edges, MSB first, and places them in bits [15:0] when the frame ends.
- R6: Busy clears by itself after the last bit of the frame. A write transaction leaves bits [15:0] holding the data that was sent.
- R7: MDC has a period of 2*CLK_HALF system clocks while a frame runs, and stays low while the block is idle.
- R8: MDIO output changes only while MDC is low.
- R9: A write to the control word while busy is set is ignored and does not disturb the running frame.
- R10: A write with busy set but enable clear starts no frame. The word reads back with busy clear on the next cycle and with the other written fields kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with CLK_HALF = 2 and a 32-bit preamble. With that setting a frame takes about 260 system clocks, so a randomised mix of reads and writes, a write collision and an enable-clear command all fit in a short run. The full-length preamble is still exercised. A PHY responder in the bench drives the second turnaround bit and the read data on MDC falling edges. It also records every bit seen on the line, so whole frames are compared bit for bit.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  // Control word; field positions are fixed by the software view.
  typedef struct packed {
    logic        busy;    // 31
    logic        en;      // 30
    logic [1:0]  rsv_hi;  // 29:28
    logic        rd;      // 27
    logic        rsv_lo;  // 26
    logic [4:0]  phy;     // 25:21
    logic [4:0]  regad;   // 20:16
    logic [15:0] data;    // 15:0
  } ctrl_t;

  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] TA_PAT    = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF - 1));
  assign rise = run && wrap && !mdc;
  assign fall = run && wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_cmd_pkg::*;
#(
  parameter int PRE = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_read,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata
);
  localparam int NB    = PRE + 32;
  localparam int IW    = $clog2(NB + 1);
  localparam int TA_IX = PRE + 14;
  localparam int D_IX  = PRE + 16;

  logic [NB-1:0] sr;
  logic [IW-1:0] idx;
  logic          rd_q;
  logic [NB-1:0] frame;

  assign frame  = {{PRE{1'b1}}, START_PAT, (is_read ? OP_READ : OP_WRITE),
                   phy, regad, TA_PAT, (is_read ? 16'h0000 : wdata)};
  assign mdio_o = sr[NB-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '1;
      idx     <= '0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        sr      <= frame;
        idx     <= '0;
        rd_q    <= is_read;
        active  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (active) begin
        if (rise && rd_q && (idx >= IW'(D_IX)))
          rdata <= {rdata[14:0], mdio_i};
        if (fall) begin
          if (idx == IW'(NB - 1)) begin
            active  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
            sr  <= {sr[NB-2:0], 1'b1};
            if (rd_q && (idx == IW'(TA_IX - 1)))
              mdio_oe <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_HALF      = 10,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  ctrl_t       ctrl;
  ctrl_t       wd;
  logic        wr_ok;
  logic        start;
  logic        active;
  logic        rise;
  logic        fall;
  logic        done;
  logic [15:0] rdata;

  assign wd      = ctrl_t'(wr_data);
  assign wr_ok   = wr_en && !ctrl.busy;
  assign start   = wr_ok && wd.busy && wd.en;
  assign rd_data = ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ok) begin
      ctrl      <= wd;
      ctrl.busy <= wd.busy & wd.en;
    end else if (done) begin
      ctrl.busy <= 1'b0;
      if (ctrl.rd)
        ctrl.data <= rdata;
    end
  end

  mdio_mdc_gen #(.HALF(CLK_HALF)) u_clk (
    .clk (clk),
    .rst (rst),
    .run (active),
    .mdc (mdc),
    .rise(rise),
    .fall(fall)
  );

  mdio_frame_shifter #(.PRE(PREAMBLE_BITS)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .is_read(wd.rd),
    .phy    (wd.phy),
    .regad  (wd.regad),
    .wdata  (wd.data),
    .rise   (rise),
    .fall   (fall),
    .mdio_i (mdio_i),
    .active (active),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .done   (done),
    .rdata  (rdata)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R8: output bit moves only with MDC low
  p_mdio_mdc_low_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  // R7: idle means MDC low and line released
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_data[31] |-> (!mdc && !mdio_oe));

  // R9: a write during busy leaves the command fields untouched
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_data[31]) |=> $stable(rd_data[30:16]));

  // R10: no enable means busy never shows
  p_no_enable_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_data[31] && wr_data[31] && !wr_data[30]) |=> !rd_data[31]);

  // R2: an accepted start reads back busy and enabled
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_data[31] && wr_data[31] && wr_data[30]) |=> (rd_data[31] && rd_data[30]));
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .mdc    (mdc),
  .mdio_o (mdio_o),
  .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_cmd_master.sv
`timescale 1ns/1ps
module tb_mdio_cmd_master;
  localparam int HALF = 2;
  localparam int PRE  = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_line;
  logic        phy_en = 1'b0, phy_val = 1'b1;

  int          checks = 0, fails = 0;
  int          bit_cnt = 0;
  logic [63:0] cap = '0;
  logic        cur_rd = 1'b0;
  logic [15:0] phy_rval = '0;
  realtime     last_rise = 0;
  int          per_bad = 0;
  int          mdc_viol = 0;
  logic        prev_mdc = 1'b0, prev_o = 1'b1;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_cmd_master #(.CLK_HALF(HALF), .PREAMBLE_BITS(PRE)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  // PHY side: record the line on MDC rise, answer reads on MDC fall
  always @(posedge mdc) begin
    cap     = {cap[62:0], mdio_line};
    bit_cnt = bit_cnt + 1;
    if (bit_cnt > 1 && ($realtime - last_rise) != (2.0 * HALF * 20.0)) per_bad++;
    last_rise = $realtime;
  end

  always @(negedge mdc) begin
    if (cur_rd && bit_cnt >= 47 && bit_cnt <= 63) begin
      phy_en  = 1'b1;
      phy_val = (bit_cnt == 47) ? 1'b0 : phy_rval[15-(bit_cnt-48)];
    end else begin
      phy_en = 1'b0;
    end
  end

  // R8 observer: output must not move across a stretch where MDC stays high
  always @(negedge clk) begin
    if (!rst && prev_mdc && mdc && (mdio_o !== prev_o)) mdc_viol++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  function automatic logic [31:0] cmd(input bit busy, input bit en, input bit rd,
                                      input logic [4:0] phy, input logic [4:0] rg,
                                      input logic [15:0] d);
    return {busy, en, 2'b00, rd, 1'b0, phy, rg, d};
  endfunction

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (rd_data[31] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 2000, req, 64'(n), 64'd0);
  endtask

  task automatic txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                     input logic [15:0] wd, input logic [15:0] rv);
    logic [63:0] ef;
    bit_cnt  = 0;
    cur_rd   = rd;
    phy_rval = rv;
    reg_write(cmd(1'b1, 1'b1, rd, phy, rg, wd));
    chk(rd_data[31] && rd_data[30], "R2 busy after start", 64'(rd_data), 64'(cmd(1'b1, 1'b1, rd, phy, rg, wd)));
    wait_idle("R6 busy clears");
    ef = exp_frame(rd, phy, rg, rd ? rv : wd);
    chk(cap == ef && bit_cnt == 64, rd ? "R4 read frame" : "R3 write frame", cap, ef);
    chk(rd_data[30:16] == cmd(1'b0, 1'b1, rd, phy, rg, wd)[30:16], "R2 fields kept",
        64'(rd_data), 64'(cmd(1'b0, 1'b1, rd, phy, rg, wd)));
    chk(rd_data[15:0] == (rd ? rv : wd), rd ? "R5 read data" : "R6 write data kept",
        64'(rd_data[15:0]), 64'(rd ? rv : wd));
    chk(!mdio_oe && !mdc, "R7 idle after frame", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] w;
    r = $urandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(rd_data == 32'd0 && !mdc && !mdio_oe, "R1 reset state",
        {29'd0, mdc, mdio_oe, 1'b0, rd_data}, 64'd0);

    // directed corners
    txn(1'b0, 5'h1f, 5'h00, 16'hA5C3, 16'h0000);
    txn(1'b1, 5'h00, 5'h1f, 16'h0000, 16'h8001);
    txn(1'b1, 5'h15, 5'h0a, 16'hFFFF, 16'hFFFF);
    chk(per_bad == 0, "R7 MDC period", 64'(per_bad), 64'd0);

    // R9: collide with a running write
    bit_cnt = 0;
    cur_rd  = 1'b0;
    reg_write(cmd(1'b1, 1'b1, 1'b0, 5'h03, 5'h04, 16'h1234));
    repeat (40) @(negedge clk);
    reg_write(cmd(1'b1, 1'b1, 1'b1, 5'h1c, 5'h1b, 16'hBEEF));
    chk(rd_data == cmd(1'b1, 1'b1, 1'b0, 5'h03, 5'h04, 16'h1234), "R9 write while busy ignored",
        64'(rd_data), 64'(cmd(1'b1, 1'b1, 1'b0, 5'h03, 5'h04, 16'h1234)));
    wait_idle("R9 frame completes");
    chk(cap == exp_frame(1'b0, 5'h03, 5'h04, 16'h1234), "R9 frame undisturbed",
        cap, exp_frame(1'b0, 5'h03, 5'h04, 16'h1234));

    // R10: enable clear
    bit_cnt = 0;
    reg_write(cmd(1'b1, 1'b0, 1'b1, 5'h07, 5'h09, 16'h0F0F));
    chk(rd_data == cmd(1'b0, 1'b0, 1'b1, 5'h07, 5'h09, 16'h0F0F), "R10 busy clears at once",
        64'(rd_data), 64'(cmd(1'b0, 1'b0, 1'b1, 5'h07, 5'h09, 16'h0F0F)));
    repeat (60) @(negedge clk);
    chk(bit_cnt == 0 && !mdio_oe, "R10 no frame", 64'(bit_cnt), 64'd0);

    // random mix
    for (int i = 0; i < 10; i++) begin
      r = $urandom;
      w = $urandom;
      txn(r[0], r[5:1], r[10:6], w[15:0], w[31:16]);
    end
    chk(per_bad == 0, "R7 MDC period random", 64'(per_bad), 64'd0);
    chk(mdc_viol == 0, "R8 MDIO stable while MDC high", 64'(mdc_viol), 64'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule